// File: doc/BRIEF.md
# Static Clock Mode Controller

This block derives a processor clock, a 50% companion clock and a half-rate peripheral clock from a reference clock that runs at twice the oscillator rate. It manages four power conditions: full-speed running, slow running, clocks held while the oscillator settles, and oscillator stopped. A single level input selects full speed (oscillator divided by 3) or slow speed (oscillator divided by 768). The block applies a change of this input only where a peripheral clock period ends, so no output ever shows a shortened phase.

The processor stops the block with a two-step status sequence. On one rising edge of the processor clock the status lines read all-high, which is the passive state. On the next rising edge they read low-high-high, which is the halt state. The block then finishes the current peripheral clock period, holds every clock low and drops its oscillator gate. A START pulse turns the oscillator back on. After a settle count of 8192 oscillator cycles the clocks resume together from the start of a frame. While START is held high, the block never stops.

Top module: `clkmode_ctrl`

## Requirements
- R1: In full-speed mode, cpu_clk repeats every 6 reference cycles (oscillator / 3) and is high for the first 2 cycles of each frame.
- R2: clk50 has the same period as cpu_clk. It rises on the same reference edge as cpu_clk and stays high for half the period: 3 cycles fast, 768 cycles slow.
- R3: pclk toggles only on rising edges of cpu_clk, which makes it cpu_clk / 2 with a 50% duty cycle. It is low during the first cpu_clk period after the clocks start.
- R4: In slow mode, cpu_clk repeats every 1536 reference cycles (oscillator / 768) and is high for 512 of them. pclk then stays high for 1536 cycles.
- R5: slow_sel is taken up only at a falling edge of pclk. Across any switch, no high phase of cpu_clk is shorter than 2 cycles, no low phase is shorter than 4, no clk50 phase is shorter than 3, and no pclk phase is shorter than 6.
- R6: stat is {stat[2], stat[1], stat[0]}, and stat[2] doubles as the STOP line. The status is sampled on each rising edge of cpu_clk. A sample of 3'b111 followed on the very next rising edge by 3'b011 is a stop command.
- R7: A 3'b011 sample that does not directly follow a 3'b111 sample has no effect. The clocks keep running.
- R8: While start_req is high, no status sequence stops the block. Any stop command that is still pending is dropped.
- R9: A stop takes effect only at a reference edge where cpu_clk is low and pclk is about to fall. After that, cpu_clk, clk50, pclk, osc_en and osc_stable are all low until a restart.
- R10: start_req high while stopped raises osc_en on the next reference cycle. osc_stable and the clocks follow exactly SETTLE_CYC (16384 reference = 8192 oscillator) cycles later. At that point cpu_clk and clk50 rise together and pclk starts low.
- R11: In reset, osc_en is 1 and osc_stable, cpu_clk, clk50 and pclk are 0. The settle count starts when reset is released, and osc_stable rises SETTLE_CYC reference cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_sel | input | 1 | 1 selects slow mode (/768), 0 selects full speed (/3) |
| start_req | input | 1 | Restart request; also blocks stopping while high |
| stat | input | 3 | Processor status lines; stat[2] doubles as the STOP line |
| cpu_clk | output | 1 | Processor clock, 1/3 high |
| clk50 | output | 1 | Companion clock, 50% duty, aligned with cpu_clk |
| pclk | output | 1 | Peripheral clock, cpu_clk / 2 |
| osc_en | output | 1 | Oscillator gate, low while stopped |
| osc_stable | output | 1 | High once the settle count has completed |

## Verification
The bench sends a halt pattern with no passive sample before it. A design that compares only the current status would stop there. The bench also holds START through a full passive-then-halt sequence and then releases it, which exposes a design that keeps a pending stop alive across START. While the speed select is switched in both directions, a monitor watches every phase length. A mode change applied mid-frame, or a stop that cuts pclk short, shows up there as a runt phase. The bench counts the restart latency exactly, so a settle counter that is off by one is reported.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int SLOW_MULT  = 256,
  parameter int SETTLE_CYC = 16384
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       slow_sel,
  input  logic       start_req,
  input  logic [2:0] stat,
  output logic       cpu_clk,
  output logic       clk50,
  output logic       pclk,
  output logic       osc_en,
  output logic       osc_stable
);
  localparam int PW = $clog2(SLOW_MULT);
  localparam int SW = $clog2(SETTLE_CYC);
  localparam logic [2:0] PASSIVE = 3'b111;
  localparam logic [2:0] HALT    = 3'b011;

  typedef enum logic [1:0] {ST_SETTLE, ST_RUN, ST_OFF} st_t;

  st_t           st;
  logic [2:0]    ph;
  logic [PW-1:0] pre;
  logic [SW-1:0] cnt;
  logic [2:0]    stat_q;
  logic          slow_q, stop_pend, pclk_q;

  wire tick      = !slow_q || (pre == PW'(SLOW_MULT - 1));
  wire running   = (st == ST_RUN);
  wire frame_end = running && tick && (ph == 3'd5);
  wire halt_seen = frame_end && !start_req && (stat_q == PASSIVE) && (stat == HALT);
  wire stop_now  = frame_end && pclk_q && !start_req && (stop_pend || halt_seen);

  assign cpu_clk    = running && (ph < 3'd2);
  assign clk50      = running && (ph < 3'd3);
  assign pclk       = pclk_q;
  assign osc_en     = (st != ST_OFF);
  assign osc_stable = running;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_SETTLE;
      ph        <= '0;
      pre       <= '0;
      cnt       <= '0;
      stat_q    <= '0;
      slow_q    <= 1'b0;
      stop_pend <= 1'b0;
      pclk_q    <= 1'b0;
    end else begin
      case (st)
        ST_SETTLE: begin
          cnt <= cnt + 1'b1;
          if (cnt == SW'(SETTLE_CYC - 1)) begin
            st        <= ST_RUN;
            ph        <= '0;
            pre       <= '0;
            pclk_q    <= 1'b0;
            slow_q    <= slow_sel;
            stat_q    <= '0;
            stop_pend <= 1'b0;
          end
        end
        ST_RUN: begin
          if (start_req) stop_pend <= 1'b0;
          if (slow_q) pre <= tick ? '0 : pre + 1'b1;
          if (tick) ph <= (ph == 3'd5) ? 3'd0 : ph + 3'd1;
          if (frame_end) begin
            stat_q <= stat;
            pclk_q <= ~pclk_q;
            if (halt_seen) stop_pend <= 1'b1;
            if (pclk_q) begin
              slow_q <= slow_sel;
              pre    <= '0;
            end
          end
          if (stop_now) begin
            st        <= ST_OFF;
            ph        <= '0;
            pre       <= '0;
            pclk_q    <= 1'b0;
            stat_q    <= '0;
            stop_pend <= 1'b0;
          end
        end
        ST_OFF: begin
          if (start_req) begin
            st  <= ST_SETTLE;
            cnt <= '0;
          end
        end
        default: st <= ST_SETTLE;
      endcase
    end
  end
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic start_req,
  input logic cpu_clk,
  input logic clk50,
  input logic pclk,
  input logic osc_en,
  input logic osc_stable
);
  AST_OFF_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk && !clk50 && !pclk && !osc_stable)); // R9

  AST_START_HOLDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (start_req && osc_en) |=> osc_en); // R8

  AST_STOP_AT_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(!cpu_clk) && $past(pclk))); // R9

  AST_RISE_TOGETHER: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(cpu_clk) |-> $rose(clk50)); // R2

  AST_PCLK_ON_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (osc_stable && $past(osc_stable) && (pclk != $past(pclk))) |-> $rose(cpu_clk)); // R3

  AST_STABLE_NEEDS_OSC: assert property (@(posedge ref_clk) disable iff (!rst_n)
    osc_stable |-> osc_en); // R10
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .start_req(start_req),
  .cpu_clk(cpu_clk), .clk50(clk50), .pclk(pclk),
  .osc_en(osc_en), .osc_stable(osc_stable)
);

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
  localparam int SETTLE = 16384;
  localparam int SMULT  = 256;
  localparam logic [2:0] EXP [12] = '{
    3'b110, 3'b110, 3'b010, 3'b000, 3'b000, 3'b000,
    3'b111, 3'b111, 3'b011, 3'b001, 3'b001, 3'b001};

  logic clk = 1'b0, rst_n = 1'b0, slow_sel = 1'b0, start_req = 1'b0;
  logic [2:0] stat = 3'b000;
  logic cpu_clk, clk50, pclk, osc_en, osc_stable;
  int checks = 0, fails = 0, cyc = 0, glitches = 0;

  clkmode_ctrl #(.SLOW_MULT(SMULT), .SETTLE_CYC(SETTLE)) dut (
    .ref_clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .start_req(start_req),
    .stat(stat), .cpu_clk(cpu_clk), .clk50(clk50), .pclk(pclk),
    .osc_en(osc_en), .osc_stable(osc_stable));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // R5 phase-length monitor
  logic cv = 1'b0, fv = 1'b0, pv = 1'b0;
  int cr = 0, fr = 0, pr = 0;
  always @(negedge clk) begin
    if (cpu_clk == cv) cr++;
    else begin
      if ((cv && cr < 2) || (!cv && cr < 4)) glitches++;
      cv = cpu_clk; cr = 1;
    end
    if (clk50 == fv) fr++;
    else begin
      if (fr < 3) glitches++;
      fv = clk50; fr = 1;
    end
    if (pclk == pv) pr++;
    else begin
      if (pr < 6) glitches++;
      pv = pclk; pr = 1;
    end
  end

  initial begin
    int n, hi, lo, h50;
    logic prev_c, prev_p;
    cycles(3);
    chk("R11 osc_en in reset", osc_en, 1);
    chk("R11 clocks low in reset", {cpu_clk, clk50, pclk, osc_stable}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!osc_stable) begin @(negedge clk); n++; end
    chk("R11 settle after reset", n, SETTLE);

    for (int i = 0; i < 12; i++) begin
      chk($sformatf("R1 R2 R3 fast frame step %0d", i), {cpu_clk, clk50, pclk}, EXP[i]);
      @(negedge clk);
    end

    // R7 halt without passive
    stat = 3'b011;
    cycles(60);
    chk("R7 lone halt ignored", osc_en, 1);
    chk("R7 still stable", osc_stable, 1);

    // R8 START blocks stop
    stat = 3'b000; cycles(12);
    start_req = 1'b1;
    stat = 3'b111; cycles(12);
    stat = 3'b011; cycles(24);
    chk("R8 no stop while start high", osc_en, 1);
    start_req = 1'b0;
    cycles(36);
    chk("R8 pending stop dropped", osc_en, 1);

    // R6 / R9 stop sequence
    stat = 3'b000; cycles(12);
    stat = 3'b111; cycles(12);
    stat = 3'b011;
    n = 0; prev_c = cpu_clk; prev_p = pclk;
    while (osc_en && n < 40) begin
      prev_c = cpu_clk; prev_p = pclk;
      @(negedge clk); n++;
    end
    chk("R6 stop on passive-then-halt", osc_en, 0);
    chk("R9 cpu_clk low before stop", prev_c, 0);
    chk("R9 pclk high before stop", prev_p, 1);
    cycles(100);
    chk("R9 all quiet when stopped", {cpu_clk, clk50, pclk, osc_en, osc_stable}, 0);

    // R10 restart
    stat = 3'b000;
    start_req = 1'b1;
    n = 0;
    while (!osc_stable && n < SETTLE + 10) begin
      @(negedge clk); n++;
      if (n == 1) begin
        chk("R10 osc_en next cycle", osc_en, 1);
        start_req = 1'b0;
      end
    end
    chk("R10 settle length", n, SETTLE + 1);
    chk("R10 clean start", {cpu_clk, clk50, pclk}, 3'b110);

    // R4 / R5 slow mode
    slow_sel = 1'b1;
    cycles(20);
    while (cpu_clk) @(negedge clk);
    while (!cpu_clk) @(negedge clk);
    hi = 0; lo = 0; h50 = 0;
    while (cpu_clk) begin hi++; if (clk50) h50++; @(negedge clk); end
    while (!cpu_clk) begin lo++; if (clk50) h50++; @(negedge clk); end
    chk("R4 slow high", hi, 2 * SMULT);
    chk("R4 slow period", hi + lo, 6 * SMULT);
    chk("R2 slow clk50 high", h50, 3 * SMULT);
    while (pclk) @(negedge clk);
    while (!pclk) @(negedge clk);
    n = 0;
    while (pclk) begin n++; @(negedge clk); end
    chk("R4 slow pclk high", n, 6 * SMULT);

    slow_sel = 1'b0;
    cycles(4000);
    while (cpu_clk) @(negedge clk);
    while (!cpu_clk) @(negedge clk);
    hi = 0; lo = 0;
    while (cpu_clk) begin hi++; @(negedge clk); end
    while (!cpu_clk) begin lo++; @(negedge clk); end
    chk("R1 fast high after switch back", hi, 2);
    chk("R1 fast period after switch back", hi + lo, 6);
    chk("R5 no runt phases", glitches, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule